// File: doc/BRIEF.md
# B3ZS Line Decoder with Code-Violation Monitor

This block sits behind a line interface that delivers bipolar line data on two rails, one for positive marks and one for negative marks, together with a recovered line clock. It turns the dual-rail stream back into a unipolar bit stream. Ordinary marks decode in the AMI manner. Zero-substitution groups, where three zeros were replaced on the line by either two spaces and a violation or by a balancing mark, a space and a violation, are detected and output as three zero bits.

Alongside the data, the block watches the line for code errors. A polarity violation that does not end a legal substitution group, a run of three or more spaces, and a bit time with both rails asserted are each reported as a line code violation. The report is a single-cycle pulse aligned with the offending bit at the data output. These pulses feed a saturating event counter and a running per-second total. A one-second tick copies the running total into a readable snapshot and starts it again. A static control input chooses whether the rails are captured on the rising or the falling edge of the line clock, so that input setup and hold can be met either way.

The decoder holds a short look-ahead window. It can then clear the balancing mark of a mark-space-violation group after the violation has arrived and before that mark leaves the block. Every bit therefore leaves the block four line clocks after it is driven.

Top module: `b3zs_rx_decoder`

## Requirements
- R1: With no substitution group present, a bit time with exactly one rail high decodes to 1 and a bit time with neither rail high decodes to 0. The value for a bit driven during clock cycle k appears at data_o during cycle k+4.
- R2: A mark whose polarity equals the previous mark (a violation) and that follows exactly two spaces is a legal space-space-violation group: the two spaces and the violation all output 0 and no violation is flagged.
- R3: A violation that follows exactly one space is a legal mark-space-violation group: the preceding mark, the space and the violation all output 0 and no violation is flagged.
- R4: A violation preceded by zero spaces, or by three or more spaces, is illegal: it outputs 1 and raises lcv_o for that bit.
- R5: Three consecutive spaces raise lcv_o once, on the third space. Further spaces in the same run raise nothing more.
- R6: A bit time with both rails high outputs 1 and raises lcv_o. It also discards the polarity reference, so that the next single-rail mark is never taken as a violation.
- R7: lcv_o is high for exactly the output cycles whose bit is in violation, and it is aligned with that bit on data_o.
- R8: lcv_count_o increases by one in the cycle after each lcv_o pulse and holds at 65535 once it gets there.
- R9: A running total counts lcv_o pulses and saturates at 65535. On the clock edge that samples sec_tick_i high, lcv_sec_o takes the running total from before that edge, and the running total restarts at 1 if lcv_o is high in that cycle and at 0 otherwise.
- R10: With fall_edge_i low the rails are captured on the rising clock edge. With fall_edge_i high they are captured on the falling edge. Latency is the same in both modes.
- R11: While rst_ni is low, data_o and lcv_o are 0 and both counters read 0. After reset there is no polarity reference, so the first mark is never a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered line clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fall_edge_i | input | 1 | 1: capture rails on the falling edge, 0: on the rising edge |
| rx_pos_i | input | 1 | Positive-mark rail |
| rx_neg_i | input | 1 | Negative-mark rail |
| sec_tick_i | input | 1 | One-second strobe, one clock wide |
| data_o | output | 1 | Decoded unipolar bit |
| lcv_o | output | 1 | Line code violation pulse, aligned with data_o |
| lcv_count_o | output | 16 | Saturating violation event count |
| lcv_sec_o | output | 16 | Violation total latched at the last tick |

## Verification
Plain alternating marks mixed with single and double spaces show whether AMI decoding works on its own, without the substitution logic triggering. Separate space-space-violation and mark-space-violation groups of both polarities show whether each group is stripped, and whether the retroactive clear hits the balancing mark and nothing else. Back-to-back same-polarity marks and violations after long space runs must be flagged, not stripped. Runs of three and of six spaces show that exactly one event is counted per run. Both-rails-high symbols followed by two same-polarity marks test how the polarity reference is dropped. Symbols that change between the falling and the next rising edge tell the two capture edges apart, and a long burst of violations drives both counters into saturation around a tick.

// File: rtl/b3zs_pkg.sv
package b3zs_pkg;
  // Look-ahead window: a violation can reach back two bit times to the balancing mark
  localparam int WIN = 3;
  localparam int CLR_STAGE = 2;

  typedef struct packed {
    logic pos;
    logic neg;
  } rail_t;

  typedef enum logic [1:0] {
    SYM_SPACE = 2'd0,
    SYM_MARK  = 2'd1,
    SYM_VIOL  = 2'd2,
    SYM_BOTH  = 2'd3
  } sym_e;
endpackage

// File: rtl/b3zs_edge_sampler.sv
module b3zs_edge_sampler
  import b3zs_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  fall_sel_i,
  input  rail_t rail_i,
  output rail_t rail_o
);
  rail_t rise_q, fall_q, fall_rt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rise_q <= '0;
    else         rise_q <= rail_i;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_q <= '0;
    else         fall_q <= rail_i;
  end

  // retime falling capture so both modes have equal latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_rt_q <= '0;
    else         fall_rt_q <= fall_q;
  end

  assign rail_o = fall_sel_i ? fall_rt_q : rise_q;
endmodule

// File: rtl/b3zs_sym_decoder.sv
module b3zs_sym_decoder
  import b3zs_pkg::*;
#(
  parameter int ZRUN_W = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  rail_t rail_i,
  output logic  bit_o,
  output logic  lcv_o,
  output logic  clr_b_o,
  output logic  v_ok_o,
  output logic  both_o
);
  localparam logic [ZRUN_W-1:0] ZRUN_MAX = '1;
  localparam logic [ZRUN_W-1:0] ZRUN_ONE = ZRUN_W'(1);
  localparam logic [ZRUN_W-1:0] ZRUN_TWO = ZRUN_W'(2);

  logic [ZRUN_W-1:0] zrun_q;
  logic              ref_ok_q;
  logic              last_neg_q;
  sym_e              sym;
  logic              v_00v, v_b0v, bad_v, zero_lcv;

  always_comb begin
    if (rail_i.pos && rail_i.neg)     sym = SYM_BOTH;
    else if (!rail_i.pos && !rail_i.neg) sym = SYM_SPACE;
    else if (ref_ok_q && (rail_i.neg == last_neg_q)) sym = SYM_VIOL;
    else                              sym = SYM_MARK;
  end

  assign v_00v    = (sym == SYM_VIOL) && (zrun_q == ZRUN_TWO);
  assign v_b0v    = (sym == SYM_VIOL) && (zrun_q == ZRUN_ONE);
  assign bad_v    = (sym == SYM_VIOL) && !v_00v && !v_b0v;
  assign zero_lcv = (sym == SYM_SPACE) && (zrun_q == ZRUN_TWO);

  assign bit_o   = (sym == SYM_BOTH) || (sym == SYM_MARK) || bad_v;
  assign lcv_o   = (sym == SYM_BOTH) || bad_v || zero_lcv;
  assign clr_b_o = v_b0v;
  assign v_ok_o  = v_00v || v_b0v;
  assign both_o  = (sym == SYM_BOTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zrun_q     <= '0;
      ref_ok_q   <= 1'b0;
      last_neg_q <= 1'b0;
    end else begin
      unique case (sym)
        SYM_BOTH: begin
          zrun_q   <= '0;
          ref_ok_q <= 1'b0;
        end
        SYM_MARK, SYM_VIOL: begin
          zrun_q     <= '0;
          ref_ok_q   <= 1'b1;
          last_neg_q <= rail_i.neg;
        end
        default: if (zrun_q != ZRUN_MAX) zrun_q <= zrun_q + 1'b1;
      endcase
    end
  end

  AST_ZERO_RUN_LCV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(zrun_q) == ZRUN_TWO && zrun_q == ZRUN_MAX) |-> $past(lcv_o)) else $error("zero run"); // R5
endmodule

// File: rtl/b3zs_align_pipe.sv
module b3zs_align_pipe
  import b3zs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic lcv_i,
  input  logic clr_i,
  output logic bit_o,
  output logic lcv_o
);
  logic [WIN-1:0] bit_q, lcv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q[0] <= 1'b0;
      lcv_q[0] <= 1'b0;
    end else begin
      bit_q[0] <= bit_i;
      lcv_q[0] <= lcv_i;
    end
  end

  for (genvar i = 1; i < WIN; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bit_q[i] <= 1'b0;
        lcv_q[i] <= 1'b0;
      end else begin
        lcv_q[i] <= lcv_q[i-1];
        if (i == CLR_STAGE) bit_q[i] <= bit_q[i-1] & ~clr_i;
        else                bit_q[i] <= bit_q[i-1];
      end
    end
  end

  assign bit_o = bit_q[WIN-1];
  assign lcv_o = lcv_q[WIN-1];
endmodule

// File: rtl/b3zs_lcv_counters.sv
module b3zs_lcv_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lcv_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] sec_o
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W-1:0] cnt_q, acc_q, sec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      acc_q <= '0;
      sec_q <= '0;
    end else begin
      if (lcv_i && cnt_q != MAXV) cnt_q <= cnt_q + 1'b1;
      if (tick_i) begin
        sec_q <= acc_q;
        acc_q <= CNT_W'(lcv_i);
      end else if (lcv_i && acc_q != MAXV) begin
        acc_q <= acc_q + 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign sec_o = sec_q;

  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cnt_q) == MAXV) |-> (cnt_q == MAXV)) else $error("cnt sat"); // R8
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(lcv_i) |-> (cnt_q == $past(cnt_q))) else $error("cnt hold"); // R8
  AST_TICK_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(tick_i) |-> (acc_q <= CNT_W'(1))) else $error("tick restart"); // R9
endmodule

// File: rtl/b3zs_rx_decoder.sv
module b3zs_rx_decoder
  import b3zs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_edge_i,
  input  logic             rx_pos_i,
  input  logic             rx_neg_i,
  input  logic             sec_tick_i,
  output logic             data_o,
  output logic             lcv_o,
  output logic [CNT_W-1:0] lcv_count_o,
  output logic [CNT_W-1:0] lcv_sec_o
);
  rail_t rail_in, rail_smp;
  logic  dec_bit, dec_lcv, dec_clr, dec_v_ok, dec_both;

  assign rail_in = '{pos: rx_pos_i, neg: rx_neg_i};

  b3zs_edge_sampler u_smp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fall_sel_i (fall_edge_i),
    .rail_i     (rail_in),
    .rail_o     (rail_smp)
  );

  b3zs_sym_decoder #(.ZRUN_W(2)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rail_i  (rail_smp),
    .bit_o   (dec_bit),
    .lcv_o   (dec_lcv),
    .clr_b_o (dec_clr),
    .v_ok_o  (dec_v_ok),
    .both_o  (dec_both)
  );

  b3zs_align_pipe u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bit_i  (dec_bit),
    .lcv_i  (dec_lcv),
    .clr_i  (dec_clr),
    .bit_o  (data_o),
    .lcv_o  (lcv_o)
  );

  b3zs_lcv_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lcv_i  (lcv_o),
    .tick_i (sec_tick_i),
    .cnt_o  (lcv_count_o),
    .sec_o  (lcv_sec_o)
  );

  AST_VIOL_OUT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dec_v_ok, WIN) |-> (!data_o && !lcv_o)) else $error("valid V output"); // R2
  AST_B0V_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dec_clr) |-> !data_o) else $error("balancing mark not cleared"); // R3
  AST_BOTH_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dec_both, WIN) |-> (data_o && lcv_o)) else $error("both rails"); // R6
endmodule

// File: tb/sim_b3zs_rx_decoder.sv
module sim_b3zs_rx_decoder;
  localparam int MAXC = 65535;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fall_edge_i = 1'b0;
  logic        rx_pos_i = 1'b0, rx_neg_i = 1'b0, sec_tick_i = 1'b0;
  logic        data_o, lcv_o;
  logic [15:0] lcv_count_o, lcv_sec_o;

  always #4 clk = ~clk;

  b3zs_rx_decoder u0 (
    .clk_i(clk), .rst_ni(rst_ni), .fall_edge_i(fall_edge_i),
    .rx_pos_i(rx_pos_i), .rx_neg_i(rx_neg_i), .sec_tick_i(sec_tick_i),
    .data_o(data_o), .lcv_o(lcv_o), .lcv_count_o(lcv_count_o), .lcv_sec_o(lcv_sec_o)
  );

  int n_chk = 0, n_bad = 0;
  // symbol codes: 0 space, 1 positive mark, 2 negative mark, 3 both rails
  int zrun; bit ref_ok, last_neg; int nfeed;
  bit exp_d[256], exp_l[256]; string tag_a[256];
  int exp_cnt, exp_acc, exp_sec;
  bit fall_mode = 1'b0;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic void model_feed(int sym, string tag);
    int idx = nfeed % 256;
    bit d = 0, l = 0;
    if (sym == 3) begin
      d = 1; l = 1; zrun = 0; ref_ok = 0;
    end else if (sym == 1 || sym == 2) begin
      bit ng = (sym == 2);
      if (ref_ok && ng == last_neg) begin
        if (zrun == 2) d = 0;
        else if (zrun == 1) begin d = 0; exp_d[(nfeed - 2) % 256] = 0; end
        else begin d = 1; l = 1; end
      end else d = 1;
      ref_ok = 1; last_neg = ng; zrun = 0;
    end else begin
      zrun++;
      if (zrun == 3) l = 1;
    end
    exp_d[idx] = d; exp_l[idx] = l; tag_a[idx] = tag;
    nfeed++;
  endfunction

  task automatic drive(int s);
    rx_pos_i = (s == 1 || s == 3);
    rx_neg_i = (s == 2 || s == 3);
  endtask

  task automatic step(int sa, int sb, string tag, bit tick = 0);
    int idx; bit l;
    @(posedge clk); #2;
    fall_edge_i = fall_mode;
    sec_tick_i = tick;
    drive(sa);
    #3 drive(sb);
    model_feed(fall_mode ? sa : sb, tag);
    #1;
    l = 0;
    if (nfeed >= 5) begin
      idx = (nfeed - 5) % 256;
      check({tag_a[idx], " data"}, int'(data_o), int'(exp_d[idx]));
      check({"R7 ", tag_a[idx], " lcv"}, int'(lcv_o), int'(exp_l[idx]));
      l = exp_l[idx];
    end
    check("R8 count", int'(lcv_count_o), exp_cnt);
    check("R9 second", int'(lcv_sec_o), exp_sec);
    if (l && exp_cnt < MAXC) exp_cnt++;
    if (tick) begin exp_sec = exp_acc; exp_acc = l; end
    else if (l && exp_acc < MAXC) exp_acc++;
  endtask

  task automatic seq(int syms[], string tag);
    foreach (syms[i]) step(syms[i], syms[i], tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, tag);
  endtask

  task automatic do_reset();
    @(posedge clk); #2;
    rst_ni = 0; sec_tick_i = 0; drive(0);
    repeat (3) @(posedge clk);
    #6;
    check("R11 reset data", int'(data_o), 0);
    check("R11 reset lcv", int'(lcv_o), 0);
    check("R11 reset count", int'(lcv_count_o), 0);
    check("R11 reset second", int'(lcv_sec_o), 0);
    @(posedge clk); #3 rst_ni = 1;
    zrun = 0; ref_ok = 0; last_neg = 0; nfeed = 0;
    exp_cnt = 0; exp_acc = 0; exp_sec = 0;
    model_feed(0, "R11"); model_feed(0, "R11");
  endtask

  task automatic t_ami();      seq('{1,0,2,1,0,2,1,2,0,1,0,0,2,1}, "R1"); idle(6, "R1"); endtask
  task automatic t_reset_ref(); seq('{2,2,0,1}, "R11"); idle(6, "R11"); endtask
  task automatic t_00v();      seq('{1,2,0,0,2,1,0,0,1,2,1}, "R2"); idle(6, "R2"); endtask
  task automatic t_b0v();      seq('{1,2,1,0,1,2,0,2,1,0,0,1}, "R3"); idle(6, "R3"); endtask
  task automatic t_badv();     seq('{1,1,2,2,0,0,0,2,1}, "R4"); idle(6, "R4"); endtask
  task automatic t_zeros();    seq('{1,0,0,0,2,0,0,0,0,0,0,1}, "R5"); idle(6, "R5"); endtask
  task automatic t_both();     seq('{1,3,1,1,2,3,3,2,0,2}, "R6"); idle(6, "R6"); endtask

  task automatic t_edge();
    for (int m = 0; m < 2; m++) begin
      fall_mode = bit'(m);
      idle(4, "R10");
      for (int i = 0; i < 6; i++) step((i % 2) ? 2 : 1, 0, "R10");
      idle(6, "R10");
    end
    fall_mode = 0;
    idle(4, "R10");
  endtask

  task automatic t_tick();
    seq('{1,1,1,1}, "R9");
    step(0, 0, "R9", 1);
    idle(3, "R9");
    seq('{2,2}, "R9");
    idle(4, "R9");
    step(0, 0, "R9", 1);
    idle(4, "R9");
  endtask

  task automatic t_sat();
    for (int i = 0; i < 66000; i++) step(3, 3, "R8");
    idle(3, "R8");
    step(0, 0, "R8", 1);
    idle(6, "R8");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    t_reset_ref();
    t_ami();
    t_00v();
    t_b0v();
    t_badv();
    t_zeros();
    t_both();
    t_edge();
    t_tick();
    t_sat();
    do_reset();
    t_reset_ref();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule